// File: doc/BRIEF.md
# Serial Configuration Register Receiver

This block takes configuration writes from a slow three-wire serial link: a serial clock, a serial data line and an active-high enable. It keeps a small file of 32-bit registers that the rest of the chip reads in parallel. These are a frequency word for each receive channel, a frequency word for each transmit channel, a packed rate word and a general-purpose word. The serial link does not share a clock with the system, so all three wires pass through synchronisers. Serial clock edges are then found by sampling in the system clock domain.

A frame is accepted only if it holds exactly forty bits between the rise and the fall of enable. The first eight bits are an address and the next thirty-two bits are data, both sent most significant bit first. When enable falls after a good frame, the addressed register is loaded. A one-cycle strobe and the frame's address are also presented, so that other logic can see that a write took place. Frames of any other length leave every register alone.

Top module: `cfg_serial_rx`

## Requirements
- R1: While reset is asserted, and after it is released, every register output reads zero and the write strobe is low.
- R2: While enable is high, a bit is taken from the data line on each rising edge of the serial clock. The first 8 bits form the address and the next 32 bits form the data word, each sent most significant bit first.
- R3: A frame with exactly 40 bits is committed when enable falls. The register value and the strobe with its address become visible after the third system clock rising edge that follows the fall of enable at the pin. The strobe lasts exactly one cycle.
- R4: Addresses 0 to 3 load receive-channel frequency words 0 to 3, which sit at bits 32*i+31:32*i of the receive output. Addresses 4 to 7 load transmit-channel words 0 to 3 in the same layout on the transmit output.
- R5: Address 8 loads the rate word. Its fields, from bit 31 down, are converter clock rate [31:24], external rate [23:16], interpolation rate [15:8] and decimation rate [7:0], and each is stored as sent.
- R6: Address 9 loads the miscellaneous word.
- R7: A 40-bit frame to an address of 10 or above, for example 19, 23 or 0x80 to 0x82, still pulses the strobe with its address. It changes no register, including those whose low address bits match.
- R8: A frame shorter than 40 bits produces no strobe and changes no register.
- R9: A frame longer than 40 bits produces no strobe and changes no register.
- R10: While enable is low, the bit count and the shifted data are held at zero. Serial clock edges seen with enable low have no effect, and the next frame is decoded from its first bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| ser_clk_i | input | 1 | Serial bit clock, asynchronous to clk |
| ser_dat_i | input | 1 | Serial data line |
| ser_en_i | input | 1 | Frame enable, active high |
| rx_freq_o | output | NUM_CHAN*32 | Receive-channel frequency words, channel i at bits 32*i+31:32*i |
| tx_freq_o | output | NUM_CHAN*32 | Transmit-channel frequency words, same layout |
| rate_o | output | 32 | Packed rate word |
| misc_o | output | 32 | Miscellaneous word |
| wr_stb_o | output | 1 | One-cycle pulse when a complete frame is accepted |
| wr_addr_o | output | 8 | Address of the last accepted frame |

## Verification
A result is due three system clock edges after enable falls at the pin: two edges for the synchroniser and one for the commit register. Each frame task therefore drops enable on a falling clock edge, waits exactly three rising edges, and then reads the strobe, the address and every register output on the next falling edge. It checks one cycle later that the strobe has cleared. Within a frame, each serial clock phase is held for four system cycles. The data line changes only while the serial clock is low, so it has settled through its own synchroniser before the rising edge is detected. Checks for discarded frames and for edges seen with enable low use the same three-edge window, so a wrong strobe or a changed register would appear in the same cycle that a correct commit would.

// File: rtl/cfg_serial_pkg.sv
package cfg_serial_pkg;
  parameter int unsigned CFG_ADDR_W = 8;
  parameter int unsigned CFG_DATA_W = 32;
  localparam int unsigned CFG_FRAME_BITS = CFG_ADDR_W + CFG_DATA_W;

  typedef struct packed {
    logic [CFG_ADDR_W-1:0] addr;
    logic [CFG_DATA_W-1:0] data;
  } cfg_wr_t;
endpackage

// File: rtl/cfg_sync.sv
module cfg_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic [STAGES-1:0] chain_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain_q <= '0;
      else        chain_q <= {chain_q[STAGES-2:0], d_i[g]};
    end
    assign q_o[g] = chain_q[STAGES-1];
  end
endmodule

// File: rtl/cfg_frame_rx.sv
module cfg_frame_rx
  import cfg_serial_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    sclk_s,
  input  logic    sdat_s,
  input  logic    sen_s,
  output logic    frame_ok_o,
  output cfg_wr_t frame_o
);
  localparam int unsigned CNT_MAX = CFG_FRAME_BITS + 1;
  localparam int unsigned CNT_W   = $clog2(CNT_MAX + 1);

  logic                      sclk_q, sen_q;
  logic [CFG_FRAME_BITS-1:0] shift_q, shift_d;
  logic [CNT_W-1:0]          cnt_q, cnt_d;
  logic                      sclk_rise, sen_fall;

  always_comb begin
    sclk_rise = sclk_s & ~sclk_q;
    sen_fall  = sen_q & ~sen_s;
    shift_d   = shift_q;
    cnt_d     = cnt_q;
    if (!sen_s) begin
      shift_d = '0;
      cnt_d   = '0;
    end else if (sclk_rise) begin
      shift_d = {shift_q[CFG_FRAME_BITS-2:0], sdat_s};
      if (cnt_q != CNT_W'(CNT_MAX)) cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q  <= 1'b0;
      sen_q   <= 1'b0;
      shift_q <= '0;
      cnt_q   <= '0;
    end else begin
      sclk_q  <= sclk_s;
      sen_q   <= sen_s;
      shift_q <= shift_d;
      cnt_q   <= cnt_d;
    end
  end

  assign frame_ok_o = sen_fall && (cnt_q == CNT_W'(CFG_FRAME_BITS));
  assign frame_o    = cfg_wr_t'(shift_q);

  // R9: the bit count saturates rather than wrapping back to a legal length
  p_cnt_cap_r9: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CNT_W'(CNT_MAX));

  // R10: after enable drops, the next frame starts from bit zero
  p_fall_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(sen_s) |=> (cnt_q == '0 && shift_q == '0));
endmodule

// File: rtl/cfg_reg_bank.sv
module cfg_reg_bank
  import cfg_serial_pkg::*;
#(
  parameter int unsigned NUM_CHAN = 4,
  localparam int unsigned NUM_REGS = 2 * NUM_CHAN + 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           wr_en_i,
  input  cfg_wr_t                        wr_i,
  output logic [NUM_REGS*CFG_DATA_W-1:0] rf_o,
  output logic                           wr_stb_o,
  output logic [CFG_ADDR_W-1:0]          wr_addr_o
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic                  hit;
    logic [CFG_DATA_W-1:0] word_q;
    assign hit = wr_en_i && (wr_i.addr == CFG_ADDR_W'(i));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   word_q <= '0;
      else if (hit) word_q <= wr_i.data;
    end
    assign rf_o[i*CFG_DATA_W +: CFG_DATA_W] = word_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_stb_o  <= 1'b0;
      wr_addr_o <= '0;
    end else begin
      wr_stb_o <= wr_en_i;
      if (wr_en_i) wr_addr_o <= wr_i.addr;
    end
  end

  // R3: the strobe never lasts two cycles
  p_stb_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
    wr_stb_o |=> !wr_stb_o);

  // R8: without an accepted frame the file holds its contents
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en_i |=> $stable(rf_o));

  // R7: unmapped addresses never alias onto a mapped register
  p_unmapped_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en_i && (int'(wr_i.addr) >= NUM_REGS)) |=> $stable(rf_o));
endmodule

// File: rtl/cfg_serial_rx.sv
module cfg_serial_rx
  import cfg_serial_pkg::*;
#(
  parameter int unsigned NUM_CHAN    = 4,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           ser_clk_i,
  input  logic                           ser_dat_i,
  input  logic                           ser_en_i,
  output logic [NUM_CHAN*CFG_DATA_W-1:0] rx_freq_o,
  output logic [NUM_CHAN*CFG_DATA_W-1:0] tx_freq_o,
  output logic [CFG_DATA_W-1:0]          rate_o,
  output logic [CFG_DATA_W-1:0]          misc_o,
  output logic                           wr_stb_o,
  output logic [CFG_ADDR_W-1:0]          wr_addr_o
);
  localparam int unsigned NUM_REGS = 2 * NUM_CHAN + 2;
  localparam int unsigned CH_BITS  = NUM_CHAN * CFG_DATA_W;

  logic [1:0] rst_pipe_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= '0;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe_q[1];

  logic [2:0] pins_s;
  cfg_sync #(.WIDTH(3), .STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_sync_n),
    .d_i   ({ser_en_i, ser_dat_i, ser_clk_i}),
    .q_o   (pins_s)
  );

  logic    frame_ok;
  cfg_wr_t frame;
  cfg_frame_rx u_frame (
    .clk        (clk),
    .rst_n      (rst_sync_n),
    .sclk_s     (pins_s[0]),
    .sdat_s     (pins_s[1]),
    .sen_s      (pins_s[2]),
    .frame_ok_o (frame_ok),
    .frame_o    (frame)
  );

  logic [NUM_REGS*CFG_DATA_W-1:0] rf;
  cfg_reg_bank #(.NUM_CHAN(NUM_CHAN)) u_bank (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .wr_en_i   (frame_ok),
    .wr_i      (frame),
    .rf_o      (rf),
    .wr_stb_o  (wr_stb_o),
    .wr_addr_o (wr_addr_o)
  );

  assign rx_freq_o = rf[CH_BITS-1:0];
  assign tx_freq_o = rf[2*CH_BITS-1:CH_BITS];
  assign rate_o    = rf[2*CH_BITS +: CFG_DATA_W];
  assign misc_o    = rf[2*CH_BITS+CFG_DATA_W +: CFG_DATA_W];
endmodule

// File: tb/tb_cfg_serial_rx.sv
module tb_cfg_serial_rx;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         ser_clk, ser_dat, ser_en;
  logic [127:0] rx_freq, tx_freq;
  logic [31:0]  rate, misc;
  logic         wr_stb;
  logic [7:0]   wr_addr;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] model [10];
  logic        got_stb, got_stb_after;
  logic [7:0]  got_addr;

  always #10 clk = ~clk;

  cfg_serial_rx dut (
    .clk(clk), .rst_n(rst_n), .ser_clk_i(ser_clk), .ser_dat_i(ser_dat),
    .ser_en_i(ser_en), .rx_freq_o(rx_freq), .tx_freq_o(tx_freq),
    .rate_o(rate), .misc_o(misc), .wr_stb_o(wr_stb), .wr_addr_o(wr_addr)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_regs(input string tag);
    for (int i = 0; i < 4; i++) begin
      chk({tag, " rx"}, rx_freq[i*32 +: 32], model[i]);
      chk({tag, " tx"}, tx_freq[i*32 +: 32], model[4+i]);
    end
    chk({tag, " rate"}, rate, model[8]);
    chk({tag, " misc"}, misc, model[9]);
  endtask

  task automatic wait_clks(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Sends the low n bits of v, MSB first, then drops enable and captures the commit window.
  task automatic send_bits(input logic [47:0] v, input int n);
    @(negedge clk);
    ser_en = 1'b1;
    wait_clks(4);
    for (int b = n - 1; b >= 0; b--) begin
      ser_dat = v[b];
      wait_clks(4);
      ser_clk = 1'b1;
      wait_clks(4);
      ser_clk = 1'b0;
    end
    wait_clks(4);
    ser_en = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    got_stb  = wr_stb;
    got_addr = wr_addr;
    @(negedge clk);
    got_stb_after = wr_stb;
  endtask

  task automatic t_reset;
    rst_n = 1'b0; ser_clk = 1'b0; ser_dat = 1'b0; ser_en = 1'b0;
    for (int i = 0; i < 10; i++) model[i] = '0;
    wait_clks(5);
    chk_regs("R1 in reset");
    chk("R1 strobe in reset", 32'(wr_stb), 32'd0);
    rst_n = 1'b1;
    wait_clks(6);
    chk_regs("R1 after release");
    chk("R1 strobe after release", 32'(wr_stb), 32'd0);
  endtask

  task automatic t_write(input string tag, input logic [7:0] a, input logic [31:0] d);
    send_bits({8'h00, a, d}, 40);
    if (a < 8'd10) model[a] = d;
    chk({tag, " R3 strobe"}, 32'(got_stb), 32'd1);
    chk({tag, " R3 address"}, 32'(got_addr), 32'(a));
    chk({tag, " R3 strobe width"}, 32'(got_stb_after), 32'd0);
    chk_regs(tag);
  endtask

  task automatic t_map;
    for (int i = 0; i < 4; i++)
      t_write("R4 rx", 8'(i), 32'h1100_0000 * (i + 1) + 32'h0000_00A5);
    for (int i = 0; i < 4; i++)
      t_write("R4 tx", 8'(4 + i), 32'h0022_0000 * (i + 1) + 32'h0000_5A00);
    t_write("R2 bit order", 8'd5, 32'h8000_0001);
    t_write("R5 rate", 8'd8, {8'd2, 8'd12, 8'h0f, 8'h07});
    chk("R5 converter rate", 32'(rate[31:24]), 32'd2);
    chk("R5 external rate", 32'(rate[23:16]), 32'd12);
    chk("R5 interp rate", 32'(rate[15:8]), 32'h0f);
    chk("R5 decim rate", 32'(rate[7:0]), 32'h07);
    t_write("R6 misc", 8'd9, 32'hC0DE_F00D);
    t_write("R2 overwrite", 8'd0, 32'h0123_4567);
  endtask

  task automatic t_unmapped;
    t_write("R7 addr 19", 8'd19, 32'hFFFF_FFFF);
    t_write("R7 addr 23", 8'd23, 32'h1234_FEDC);
    t_write("R7 addr 0x80", 8'h80, 32'hFFFF_FFFF);
    t_write("R7 addr 0x81", 8'h81, 32'hFFFF_FFFF);
    t_write("R7 addr 0x82", 8'h82, 32'hFFFF_FFFF);
  endtask

  task automatic t_bad_length;
    send_bits({8'h00, 8'd3, 32'hDEAD_BEEF} >> 1, 39);
    chk("R8 short strobe", 32'(got_stb), 32'd0);
    chk_regs("R8 short");
    send_bits({7'h00, 8'd3, 32'hDEAD_BEEF, 1'b1}, 41);
    chk("R9 long strobe", 32'(got_stb), 32'd0);
    chk_regs("R9 long");
  endtask

  task automatic t_idle_edges;
    ser_dat = 1'b1;
    for (int k = 0; k < 5; k++) begin
      wait_clks(4); ser_clk = 1'b1;
      wait_clks(4); ser_clk = 1'b0;
    end
    wait_clks(4);
    chk("R10 no strobe from idle edges", 32'(wr_stb), 32'd0);
    chk_regs("R10 idle edges");
    t_write("R10 frame after idle edges", 8'd9, 32'h0000_0003);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    t_reset();
    t_map();
    t_unmapped();
    t_bad_length();
    t_idle_edges();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule